// File: doc/BRIEF.md
# Register/Literal Integer Execute Unit

This block is the arithmetic and logic stage of a small 32-bit load/store processor. It takes a 6-bit operation code, the values of two source registers and the 16-bit immediate field of the instruction. It produces one 32-bit result and a flag that says whether the operation code is one the unit implements. The unit computes add, subtract, multiply, divide, three signed relations, three bitwise operations and three kinds of shift.

One bit of the operation code picks the second operand. When that bit is clear, the second operand is the second register value. When it is set, the second operand is the immediate, sign-extended to 32 bits. Every operation therefore exists in a register form and in an immediate form, and the two codes differ by 0x10. Both outputs are registered, so a result appears one clock after its inputs are presented. The surrounding instruction decoder feeds the unit from the instruction word: the operation code is bits 31:26 and the immediate is bits 15:0.

Top module: `exec_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` and `legal` are both 0 after that edge.
- R2: The register-form codes are 0x20 add, 0x21 subtract, 0x22 multiply, 0x23 divide, 0x24 equal, 0x25 signed less-than, 0x26 signed less-or-equal, 0x28 AND, 0x29 OR, 0x2A XOR, 0x2C shift left, 0x2D logical shift right and 0x2E arithmetic shift right. For any of these codes, `legal` is 1 one clock after the code is presented, and `result` holds the value of that operation.
- R3: Opcode bit 4 selects the second operand. When bit 4 is 1 (codes 0x30 to 0x3E), the second operand is `lit` sign-extended from bit 15, and `rb_val` has no effect. When bit 4 is 0, `rb_val` is the second operand, and `lit` has no effect.
- R4: Add and subtract wrap modulo 2^32.
- R5: Multiply returns the low 32 bits of the product.
- R6: Divide treats both operands as signed and truncates the quotient toward zero. A zero divisor gives 0xFFFFFFFF. The quotient -2^31 / -1 gives 0x80000000.
- R7: The three relations return exactly 1 when they hold and 0 otherwise. Less-than and less-or-equal compare the operands as signed two's-complement values.
- R8: AND, OR and XOR operate bit by bit on the two operands.
- R9: Shifts use only bits 4:0 of the second operand as the count. Left shift and logical right shift fill the freed bit positions with 0.
- R10: Arithmetic right shift fills the freed bit positions with bit 31 of the first operand.
- R11: Any other code drives `legal` to 0 and `result` to 0. This covers every code with bit 5 clear, and the low nibbles 0x7, 0xB and 0xF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Operation code |
| ra_val | input | 32 | First operand (first source register) |
| rb_val | input | 32 | Second source register value |
| lit | input | 16 | Immediate field, sign-extended when used |
| result | output | 32 | Registered result |
| legal | output | 1 | Registered flag: the code is implemented |

## Verification
The assertions check four properties on every clock cycle: an illegal code always leaves a zero result, a relation never sets a bit above bit 0, a zero divisor always gives all ones, and an arithmetic shift of a negative operand keeps the sign bit. Other behaviour can only be shown by the bench's scenarios against its reference model. This includes the exact arithmetic values, truncation toward zero, the -2^31 / -1 case, shift counts of 32 and above, and the signed ordering at the extremes. It also includes the fact that the unused operand has no effect in each form, which the bench shows by changing that operand while holding the others fixed.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int OP_W      = 6;
  localparam int FN_W      = 4;
  localparam int LIT_SEL   = 4;  // opcode bit choosing the immediate operand
  localparam int CLASS_BIT = 5;  // opcode bit marking the execute group

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 4'h0,
    FN_SUB = 4'h1,
    FN_MUL = 4'h2,
    FN_DIV = 4'h3,
    FN_CEQ = 4'h4,
    FN_CLT = 4'h5,
    FN_CLE = 4'h6,
    FN_AND = 4'h8,
    FN_OR  = 4'h9,
    FN_XOR = 4'hA,
    FN_SHL = 4'hC,
    FN_SHR = 4'hD,
    FN_SRA = 4'hE
  } fn_e;

  function automatic logic fn_known(input logic [FN_W-1:0] f);
    return !(f == 4'h7 || f == 4'hB || f == 4'hF);
  endfunction
endpackage

// File: rtl/exec_operand_mux.sv
module exec_operand_mux #(
  parameter int DATA_W = 32,
  parameter int LIT_W  = 16
) (
  input  logic              use_lit,
  input  logic [DATA_W-1:0] rb_val,
  input  logic [LIT_W-1:0]  lit,
  output logic [DATA_W-1:0] op_b
);
  logic [DATA_W-1:0] lit_ext;

  generate
    if (LIT_W < DATA_W) begin : g_sext
      assign lit_ext = {{(DATA_W-LIT_W){lit[LIT_W-1]}}, lit};
    end else begin : g_trunc
      assign lit_ext = lit[DATA_W-1:0];
    end
  endgenerate

  assign op_b = use_lit ? lit_ext : rb_val;
endmodule

// File: rtl/exec_arith.sv
module exec_arith
  import exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fn_e               fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] mag_a, mag_b, mag_q, quo;
  logic              neg_q, lt, eq;

  always_comb begin
    mag_a = a[DATA_W-1] ? (~a + 1'b1) : a;
    mag_b = b[DATA_W-1] ? (~b + 1'b1) : b;
    neg_q = a[DATA_W-1] ^ b[DATA_W-1];
    mag_q = (mag_b == '0) ? '0 : (mag_a / mag_b);
    if (b == '0)      quo = '1;
    else if (neg_q)   quo = ~mag_q + 1'b1;
    else              quo = mag_q;
    eq = (a == b);
    lt = ($signed(a) < $signed(b));
    case (fn)
      FN_ADD:  res = a + b;
      FN_SUB:  res = a - b;
      FN_MUL:  res = a * b;
      FN_DIV:  res = quo;
      FN_CEQ:  res = {{(DATA_W-1){1'b0}}, eq};
      FN_CLT:  res = {{(DATA_W-1){1'b0}}, lt};
      FN_CLE:  res = {{(DATA_W-1){1'b0}}, lt | eq};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/exec_bitops.sv
module exec_bitops
  import exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fn_e               fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]          shamt;
  logic signed [DATA_W-1:0] sra_v;

  always_comb begin
    shamt = b[SH_W-1:0];
    sra_v = $signed(a) >>> shamt;
    case (fn)
      FN_AND:  res = a & b;
      FN_OR:   res = a | b;
      FN_XOR:  res = a ^ b;
      FN_SHL:  res = a << shamt;
      FN_SHR:  res = a >> shamt;
      FN_SRA:  res = sra_v;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LIT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] ra_val,
  input  logic [DATA_W-1:0] rb_val,
  input  logic [LIT_W-1:0]  lit,
  output logic [DATA_W-1:0] result,
  output logic              legal
);
  fn_e               fn;
  logic              legal_d;
  logic [DATA_W-1:0] op_b, ar_res, bit_res, res_d;
  logic [DATA_W-1:0] result_q;
  logic              legal_q;

  assign fn      = fn_e'(opcode[FN_W-1:0]);
  assign legal_d = opcode[CLASS_BIT] && fn_known(opcode[FN_W-1:0]);

  exec_operand_mux #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_opmux (
    .use_lit (opcode[LIT_SEL]),
    .rb_val  (rb_val),
    .lit     (lit),
    .op_b    (op_b)
  );

  exec_arith #(.DATA_W(DATA_W)) u_arith (
    .fn  (fn),
    .a   (ra_val),
    .b   (op_b),
    .res (ar_res)
  );

  exec_bitops #(.DATA_W(DATA_W)) u_bitops (
    .fn  (fn),
    .a   (ra_val),
    .b   (op_b),
    .res (bit_res)
  );

  assign res_d = !legal_d ? '0 : (opcode[FN_W-1] ? bit_res : ar_res);

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      legal_q  <= 1'b0;
    end else begin
      result_q <= res_d;
      legal_q  <= legal_d;
    end
  end

  assign result = result_q;
  assign legal  = legal_q;

  // Input-side conditions watched by the checks below
  logic is_cmp_in, div_zero_in, sra_neg_in;
  assign is_cmp_in   = opcode[CLASS_BIT] &&
                       (fn == FN_CEQ || fn == FN_CLT || fn == FN_CLE);
  assign div_zero_in = opcode[CLASS_BIT] && fn == FN_DIV && op_b == '0;
  assign sra_neg_in  = opcode[CLASS_BIT] && fn == FN_SRA && ra_val[DATA_W-1];

  assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !legal |-> result == '0);

  assert_cmp_bool_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(is_cmp_in)) |-> result[DATA_W-1:1] == '0);

  assert_div_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(div_zero_in)) |-> (result == '1 && legal));

  assert_sra_sign_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sra_neg_in)) |-> result[DATA_W-1]);
endmodule

// File: tb/test_exec_unit.sv
`timescale 1ns/1ps
module test_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = '0;
  logic [31:0] ra_val = '0, rb_val = '0;
  logic [15:0] lit = '0;
  logic [31:0] result;
  logic        legal;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exec_unit i_exec_unit (
    .clk(clk), .rst(rst), .opcode(opcode), .ra_val(ra_val),
    .rb_val(rb_val), .lit(lit), .result(result), .legal(legal)
  );

  function automatic string tag_of(input logic [5:0] op);
    if (!op[5]) return "R11";
    case (op[3:0])
      4'h0, 4'h1: return "R4";
      4'h2: return "R5";
      4'h3: return "R6";
      4'h4, 4'h5, 4'h6: return "R7";
      4'h8, 4'h9, 4'hA: return "R8";
      4'hC, 4'hD: return "R9";
      4'hE: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Behavioural reference model
  function automatic void model(input logic [5:0] op, input logic [31:0] a,
                                input logic [31:0] rb, input logic [15:0] l,
                                output logic [31:0] r, output logic ok);
    logic [31:0] b;
    longint sa, sb, q;
    int sh;
    b  = op[4] ? {{16{l[15]}}, l} : rb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    sh = int'(b % 32);
    ok = 1'b1;
    r  = '0;
    if (!op[5]) begin ok = 1'b0; return; end
    case (op[3:0])
      4'h0: r = a + b;
      4'h1: r = a - b;
      4'h2: begin q = sa * sb; r = q[31:0]; end
      4'h3: begin
        if (b == 0) r = 32'hFFFF_FFFF;
        else begin q = sa / sb; r = q[31:0]; end
      end
      4'h4: r = (sa == sb) ? 1 : 0;
      4'h5: r = (sa <  sb) ? 1 : 0;
      4'h6: r = (sa <= sb) ? 1 : 0;
      4'h8: r = a & b;
      4'h9: r = a | b;
      4'hA: r = a ^ b;
      4'hC: begin r = a; for (int i = 0; i < sh; i++) r = {r[30:0], 1'b0}; end
      4'hD: begin r = a; for (int i = 0; i < sh; i++) r = {1'b0, r[31:1]}; end
      4'hE: begin r = a; for (int i = 0; i < sh; i++) r = {a[31], r[31:1]}; end
      default: ok = 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] er, input logic el);
    checks++;
    if (result !== er || legal !== el) begin
      errors++;
      $display("FAIL %s: result=%h legal=%b expected result=%h legal=%b",
               tag, result, legal, er, el);
    end
  endtask

  task automatic run(input logic [5:0] op, input logic [31:0] a,
                     input logic [31:0] rb, input logic [15:0] l,
                     input string tag);
    logic [31:0] er;
    logic el;
    @(negedge clk);
    opcode = op; ra_val = a; rb_val = rb; lit = l;
    model(op, a, rb, l, er, el);
    @(negedge clk);
    check(tag, er, el);
  endtask

  task automatic run_exp(input logic [5:0] op, input logic [31:0] a,
                         input logic [31:0] rb, input logic [15:0] l,
                         input logic [31:0] er, input string tag);
    @(negedge clk);
    opcode = op; ra_val = a; rb_val = rb; lit = l;
    @(negedge clk);
    check(tag, er, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 1'b0);
    rst = 1'b0;

    // R2 / R11: every opcode under two operand patterns
    for (int op = 0; op < 64; op++) begin
      run(6'(op), 32'h8765_4321, 32'h0000_0023, 16'hFFF3, tag_of(6'(op)));
      run(6'(op), 32'h0000_7FFF, 32'hFFFF_FFF9, 16'h0004, tag_of(6'(op)));
    end

    // R3: unused operand has no effect in each form
    run_exp(6'h30, 32'd10, 32'd999, 16'hFFFF, 32'd9, "R3 lit sext");
    run_exp(6'h30, 32'd10, 32'd5,   16'hFFFF, 32'd9, "R3 rb ignored");
    run_exp(6'h20, 32'd10, 32'd5,   16'h1234, 32'd15, "R3 lit ignored");
    // R4 wrap
    run_exp(6'h20, 32'hFFFF_FFFF, 32'd2, 16'h0, 32'd1, "R4 add wrap");
    run_exp(6'h21, 32'd0, 32'd1, 16'h0, 32'hFFFF_FFFF, "R4 sub wrap");
    // R5
    run_exp(6'h32, 32'h0001_0001, 32'h0, 16'hFFFF, 32'hFFFE_FFFF, "R5 mul neg lit");
    // R6 divide corners
    run_exp(6'h23, 32'hFFFF_FFF9, 32'd2, 16'h0, 32'hFFFF_FFFD, "R6 -7/2");
    run_exp(6'h23, 32'd7, 32'hFFFF_FFFE, 16'h0, 32'hFFFF_FFFD, "R6 7/-2");
    run_exp(6'h33, 32'd123, 32'd5, 16'h0000, 32'hFFFF_FFFF, "R6 div by zero lit");
    run_exp(6'h23, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 32'h8000_0000, "R6 min/-1");
    // R7 signed ordering at extremes
    run_exp(6'h25, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 32'd1, "R7 min<max");
    run_exp(6'h26, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 32'd0, "R7 max<=min");
    run_exp(6'h36, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 32'd1, "R7 le equal lit");
    run_exp(6'h34, 32'h0000_FFFF, 32'h0, 16'hFFFF, 32'd0, "R7 eq sext");
    // R8
    run_exp(6'h3A, 32'h1234_5678, 32'h0, 16'h00FF, 32'h1234_5687, "R8 xor lit");
    // R9 shift count low five bits
    run_exp(6'h2C, 32'h0000_0001, 32'd32, 16'h0, 32'h0000_0001, "R9 shl by 32");
    run_exp(6'h2C, 32'h0000_0001, 32'd37, 16'h0, 32'h0000_0020, "R9 shl by 37");
    run_exp(6'h3D, 32'h8000_0000, 32'h0, 16'h001F, 32'h0000_0001, "R9 shr by 31");
    // R10
    run_exp(6'h2E, 32'h8000_0000, 32'd31, 16'h0, 32'hFFFF_FFFF, "R10 sra sign fill");
    run_exp(6'h3E, 32'h4000_0000, 32'h0, 16'h0021, 32'h2000_0000, "R10 sra positive");
    // R11 after legal traffic
    run(6'h27, 32'hDEAD_BEEF, 32'h1, 16'h1, "R11 hole 0x27");
    run(6'h1F, 32'hDEAD_BEEF, 32'h1, 16'h1, "R11 bit5 clear");

    // Random sweep against the model
    for (int k = 0; k < 400; k++) begin
      logic [5:0] op;
      op = 6'($urandom_range(0, 63));
      run(op, $urandom, $urandom, 16'($urandom), tag_of(op));
    end

    // R1 again: reset clears outputs
    @(negedge clk);
    opcode = 6'h20; ra_val = 32'd5; rb_val = 32'd6; rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run", 32'h0, 1'b0);
    rst = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: result=%h legal=%b expected completion", result, legal);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule